// File: doc/BRIEF.md
# Signed/Unsigned 64-by-32 Integer Divider

This block divides a 64-bit dividend, supplied as a high and a low 32-bit word, by a 32-bit divisor. It takes several cycles per operation. A mode input chooses two's-complement or unsigned arithmetic. The block returns a 32-bit remainder and a 32-bit quotient. It also returns five condition flags, built from a flag word supplied with the operands, and a strobe that reports a zero divisor.

A client raises `start` for one cycle while `busy` is low. The block then holds `busy` high until it posts the result. It pulses `done` for exactly one cycle, and the outputs are registered and stay valid until the next result.

Some cases finish early: a zero divisor, a zero dividend, a dividend below the divisor, and a dividend high word too large for the result. All other operations run long division in radix 2^16. A divisor below 2^16 takes a direct path of two 32/16 digit steps. A wider divisor is first normalised. Each quotient digit then comes from a trial estimate, which is refined once and corrected by a single add-back when the trial subtraction goes negative.

Top module: `wide_divider`

## Requirements
- R1: After reset `busy`, `done`, `div_zero` and all result outputs are zero. A `start` seen while idle makes `busy` high from the next cycle until the result is posted. `done` is high for exactly one cycle with `busy` low. A `start` while busy is ignored.
- R2: A zero divisor gives `div_zero`=1 together with `done`. `rem_out` then holds the dividend high word, `quo_out` holds the dividend low word, and `flags_out` equals `flags_in`.
- R3: In unsigned mode (`sgn_mode`=0), when no overflow occurs, `quo_out` is floor(dividend/divisor) and `rem_out` is dividend mod divisor.
- R4: When the high word of the dividend magnitude is greater than or equal to the divisor magnitude, the result overflows. `rem_out`/`quo_out` then return the original high/low dividend words. `flags_out` sets V, clears C, and keeps X, N and Z from `flags_in`.
- R5: In signed mode, the division runs on magnitudes. The quotient is negative exactly when the operand signs differ, and the remainder takes the sign of the dividend.
- R6: In signed mode, a negative quotient whose magnitude exceeds 0x80000000 overflows as in R4. So does a positive quotient whose magnitude has bit 31 set.
- R7: A zero dividend with a nonzero divisor gives quotient 0, remainder 0 and Z=1.
- R8: When the dividend magnitude high word is zero and the divisor magnitude exceeds the low word, the quotient is 0 and the remainder is the (signed) dividend low word.
- R9: The flag word is 5 bits: X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. On a normal result, X is copied from `flags_in`, N is quotient bit 31, Z is set when the quotient is zero, and V and C are cleared.
- R10: Divisor magnitudes below 2^16 produce correct results through two successive 32/16 digit steps. Each step carries its partial remainder into the next.
- R11: Divisor magnitudes of 2^16 and above produce correct results for every normalisation shift count from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| sgn_mode | input | 1 | 1 = signed, 0 = unsigned |
| dvd_hi | input | 32 | Dividend high word |
| dvd_lo | input | 32 | Dividend low word |
| dvsr | input | 32 | Divisor |
| flags_in | input | 5 | Incoming flag word {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| div_zero | output | 1 | Zero-divisor strobe, coincident with done |
| rem_out | output | 32 | First result word: remainder (or dividend high word) |
| quo_out | output | 32 | Second result word: quotient (or dividend low word) |
| flags_out | output | 5 | Resulting flag word {X,N,Z,V,C} |

## Verification
Some rules hold on every cycle and the assertions check them continuously:
- `done` is one cycle long, and `busy` is low while it is high.
- A zero divisor or an overflow returns the untouched dividend words with the required flag pattern.
- Normal results carry N and Z consistent with the quotient.
- Each digit step leaves a partial remainder below the normalised divisor.
- Normalisation never needs more than fifteen shifts.

The arithmetic values themselves can only be shown by the bench's scenarios, which compare against an independent 64-bit model. These include the signed sign rules and the range limits on the quotient, the early-exit cases, both digit paths at every shift count, and a sweep of pseudo-random operands.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  localparam int FLAG_W = 5;
  localparam int F_C = 0;
  localparam int F_V = 1;
  localparam int F_Z = 2;
  localparam int F_N = 3;
  localparam int F_X = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLASS,
    S_NORM,
    S_DIGIT,
    S_FIN
  } wdiv_state_e;

  typedef enum logic [1:0] {
    K_NORM,
    K_OVF,
    K_DZ
  } wdiv_kind_e;
endpackage

// File: rtl/wdiv_mag.sv
// Two's-complement magnitude of an operand when signed arithmetic is enabled.
module wdiv_mag #(
  parameter int N = 32
) (
  input  logic         en,
  input  logic [N-1:0] val,
  output logic         neg,
  output logic [N-1:0] mag
);
  always_comb begin
    neg = en & val[N-1];
    mag = neg ? (~val + N'(1)) : val;
  end
endmodule

// File: rtl/wdiv_digit.sv
// One radix-2^(W/2) quotient digit. The window holds three half-words:
// partial remainder (W bits) followed by the next dividend half-word.
module wdiv_digit #(
  parameter int W = 32
) (
  input  logic                 short_m,
  input  logic [W+W/2-1:0]     win,
  input  logic [W-1:0]         dv,
  output logic [W/2-1:0]       q,
  output logic [W-1:0]         r
);
  localparam int H  = W / 2;
  localparam int WH = W + H;

  logic [W-1:0]  num, quot, qv1, qv2, lhs, rshort, rlong;
  logic [H-1:0]  den, den_safe, u1, u3, v1, v2, qhat, qtest, qlong, qshort;
  logic [W:0]    rhat;
  logic [WH-1:0] prod;
  logic [WH:0]   diff;
  logic          too_big;

  always_comb begin
    // shared 32/16 divider: short path divides by the whole divisor,
    // long path estimates from the top half-words
    num      = short_m ? win[W-1:0] : win[WH-1:H];
    den      = short_m ? dv[H-1:0]  : dv[W-1:H];
    den_safe = (den == '0) ? H'(1) : den;
    quot     = num / W'(den_safe);

    qshort = quot[H-1:0];
    rshort = num - W'(qshort) * W'(den_safe);

    u1 = win[WH-1:W];
    u3 = win[H-1:0];
    v1 = dv[W-1:H];
    v2 = dv[H-1:0];

    qhat = (u1 == v1) ? '1 : quot[H-1:0];
    qv1  = W'(qhat) * W'(v1);
    rhat = {1'b0, num} - {1'b0, qv1};
    qv2  = W'(qhat) * W'(v2);
    lhs  = {rhat[H-1:0], u3};
    too_big = (rhat[W:H] == '0) && (qv2 > lhs);
    qtest = too_big ? (qhat - H'(1)) : qhat;

    prod = WH'(qtest) * WH'(dv);
    diff = {1'b0, win} - {1'b0, prod};
    if (diff[WH]) begin
      qlong = qtest - H'(1);
      rlong = diff[W-1:0] + dv;
    end else begin
      qlong = qtest;
      rlong = diff[W-1:0];
    end

    q = short_m ? qshort : qlong;
    r = short_m ? rshort : rlong;
  end
endmodule

// File: rtl/wdiv_fix.sv
// Applies signs, the signed range check and the flag rules to a raw result.
module wdiv_fix
  import wdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  wdiv_kind_e        kind,
  input  logic              sgn_m,
  input  logic              neg_dvr,
  input  logic              neg_dvd,
  input  logic [W-1:0]      qmag,
  input  logic [W-1:0]      rmag,
  input  logic [W-1:0]      raw_hi,
  input  logic [W-1:0]      raw_lo,
  input  logic [FLAG_W-1:0] fin,
  output logic [W-1:0]      rem_o,
  output logic [W-1:0]      quo_o,
  output logic [FLAG_W-1:0] flg_o,
  output logic              dz_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic qneg, sovf;
  logic [W-1:0] qs;

  always_comb begin
    qneg = sgn_m & (neg_dvr ^ neg_dvd);
    sovf = sgn_m & (qneg ? (qmag > MIN_NEG) : qmag[W-1]);
    qs   = qneg ? (~qmag + W'(1)) : qmag;
    dz_o  = 1'b0;
    rem_o = raw_hi;
    quo_o = raw_lo;
    flg_o = fin;
    if (kind == K_DZ) begin
      dz_o = 1'b1;
    end else if (kind == K_OVF || sovf) begin
      flg_o      = fin;
      flg_o[F_V] = 1'b1;
      flg_o[F_C] = 1'b0;
    end else begin
      quo_o = qs;
      rem_o = (sgn_m & neg_dvd) ? (~rmag + W'(1)) : rmag;
      flg_o      = '0;
      flg_o[F_X] = fin[F_X];
      flg_o[F_N] = qs[W-1];
      flg_o[F_Z] = (qs == '0);
    end
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sgn_mode,
  input  logic [W-1:0]      dvd_hi,
  input  logic [W-1:0]      dvd_lo,
  input  logic [W-1:0]      dvsr,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic              div_zero,
  output logic [W-1:0]      rem_out,
  output logic [W-1:0]      quo_out,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int DW = 2 * W;
  localparam int H  = W / 2;
  localparam int CW = $clog2(W);

  wdiv_state_e       st;
  wdiv_kind_e        kind;
  logic              sgn_r, ndvr, ndvd, short_r, dsel;
  logic [FLAG_W-1:0] fin_r;
  logic [W-1:0]      raw_hi, raw_lo, dv, quo_m;
  logic [DW-1:0]     part;
  logic [CW-1:0]     cnt;

  // operand magnitudes at the capture edge
  logic          in_ndvd, in_ndvr;
  logic [DW-1:0] in_dmag;
  logic [W-1:0]  in_vmag;

  wdiv_mag #(.N(DW)) u_mag_dvd (
    .en(sgn_mode), .val({dvd_hi, dvd_lo}), .neg(in_ndvd), .mag(in_dmag)
  );
  wdiv_mag #(.N(W)) u_mag_dvr (
    .en(sgn_mode), .val(dvsr), .neg(in_ndvr), .mag(in_vmag)
  );

  logic [H-1:0] dq;
  logic [W-1:0] dr;

  wdiv_digit #(.W(W)) u_digit (
    .short_m(short_r), .win(part[DW-1:H]), .dv(dv), .q(dq), .r(dr)
  );

  logic [W-1:0]      fx_rem, fx_quo, rmag;
  logic [FLAG_W-1:0] fx_flg;
  logic              fx_dz;

  assign rmag = part[DW-1:W] >> cnt;

  wdiv_fix #(.W(W)) u_fix (
    .kind(kind), .sgn_m(sgn_r), .neg_dvr(ndvr), .neg_dvd(ndvd),
    .qmag(quo_m), .rmag(rmag), .raw_hi(raw_hi), .raw_lo(raw_lo),
    .fin(fin_r), .rem_o(fx_rem), .quo_o(fx_quo), .flg_o(fx_flg), .dz_o(fx_dz)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      kind      <= K_NORM;
      sgn_r     <= 1'b0;
      ndvr      <= 1'b0;
      ndvd      <= 1'b0;
      short_r   <= 1'b0;
      dsel      <= 1'b0;
      fin_r     <= '0;
      raw_hi    <= '0;
      raw_lo    <= '0;
      dv        <= '0;
      quo_m     <= '0;
      part      <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
      rem_out   <= '0;
      quo_out   <= '0;
      flags_out <= '0;
    end else begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            sgn_r   <= sgn_mode;
            ndvr    <= in_ndvr;
            ndvd    <= in_ndvd;
            fin_r   <= flags_in;
            raw_hi  <= dvd_hi;
            raw_lo  <= dvd_lo;
            part    <= in_dmag;
            dv      <= in_vmag;
            kind    <= K_NORM;
            quo_m   <= '0;
            cnt     <= '0;
            dsel    <= 1'b0;
            short_r <= 1'b0;
            st      <= S_CLASS;
          end
        end
        S_CLASS: begin
          if (dv == '0) begin
            kind <= K_DZ;
            st   <= S_FIN;
          end else if (part == '0) begin
            st <= S_FIN;
          end else if (part[DW-1:W] == '0 && dv > part[W-1:0]) begin
            part <= {part[W-1:0], {W{1'b0}}};
            st   <= S_FIN;
          end else if (part[DW-1:W] >= dv) begin
            kind <= K_OVF;
            st   <= S_FIN;
          end else begin
            short_r <= (dv[W-1:H] == '0);
            st      <= S_NORM;
          end
        end
        S_NORM: begin
          if (short_r || dv[W-1]) begin
            st <= S_DIGIT;
          end else begin
            dv   <= dv << 1;
            part <= part << 1;
            cnt  <= cnt + CW'(1);
          end
        end
        S_DIGIT: begin
          quo_m <= {quo_m[W-H-1:0], dq};
          part  <= {dr, part[H-1:0], {H{1'b0}}};
          dsel  <= 1'b1;
          if (dsel) st <= S_FIN;
        end
        S_FIN: begin
          rem_out   <= fx_rem;
          quo_out   <= fx_quo;
          flags_out <= fx_flg;
          div_zero  <= fx_dz;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: result strobe lasts a single cycle and the block is idle with it
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: zero divisor returns the captured words and flags untouched
  a_r2_dz_passthru: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (done && rem_out == raw_hi && quo_out == raw_lo && flags_out == fin_r));

  // R4: overflow keeps dividend words and clears carry
  a_r4_ovf_words: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && flags_out[F_V]) |->
      (!flags_out[F_C] && rem_out == raw_hi && quo_out == raw_lo &&
       flags_out[F_X] == fin_r[F_X]));

  // R9: normal result flags follow the quotient
  a_r9_norm_flags: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && !flags_out[F_V]) |->
      (flags_out[F_Z] == (quo_out == '0) && flags_out[F_N] == quo_out[W-1] &&
       flags_out[F_X] == fin_r[F_X] && !flags_out[F_C]));

  // R10: every digit step leaves a partial remainder below the divisor
  a_r10_digit_rem: assert property (@(posedge clk) disable iff (rst)
    (st == S_DIGIT) |-> (dr < dv));

  // R11: normalisation of a wide divisor needs fewer than H shifts
  a_r11_norm_bound: assert property (@(posedge clk) disable iff (rst)
    (st == S_NORM) |-> (cnt < CW'(H)));
endmodule

// File: tb/wide_divider_test.sv
module wide_divider_test;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sgn_mode = 1'b0;
  logic [31:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
  logic [4:0]  flags_in = '0;
  logic        busy, done, div_zero;
  logic [31:0] rem_out, quo_out;
  logic [4:0]  flags_out;

  int total = 0;
  int bad = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #5 clk = ~clk;

  wide_divider #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .sgn_mode(sgn_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr), .flags_in(flags_in),
    .busy(busy), .done(done), .div_zero(div_zero),
    .rem_out(rem_out), .quo_out(quo_out), .flags_out(flags_out)
  );

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  // returns {dz, flags, rem, quo}
  function automatic logic [69:0] model(input logic s, input logic [31:0] hi,
      input logic [31:0] lo, input logic [31:0] d, input logic [4:0] fin);
    logic [63:0] um, q64, r64;
    logic [31:0] dm, q, r;
    logic nd, nv, qn;
    logic [4:0] ovf_f;
    ovf_f = {fin[4:2], 2'b10};
    if (d == 0) return {1'b1, fin, hi, lo};
    um = {hi, lo}; dm = d; nd = 1'b0; nv = 1'b0;
    if (s) begin
      nv = d[31]; nd = hi[31];
      if (nv) dm = -d;
      if (nd) um = -um;
    end
    if (um[63:32] >= dm) return {1'b0, ovf_f, hi, lo};
    q64 = um / {32'd0, dm};
    r64 = um % {32'd0, dm};
    q = q64[31:0]; r = r64[31:0];
    if (s) begin
      qn = nv ^ nd;
      if (qn && q > 32'h8000_0000) return {1'b0, ovf_f, hi, lo};
      if (!qn && q[31]) return {1'b0, ovf_f, hi, lo};
      if (qn) q = -q;
      if (nd) r = -r;
    end
    return {1'b0, fin[4], q[31], q == 0, 2'b00, r, q};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk({req, " done timeout"}, 32'd0, 32'd1);
  endtask

  task automatic run(input string req, input logic s, input logic [31:0] hi,
      input logic [31:0] lo, input logic [31:0] d, input logic [4:0] fin);
    logic [69:0] e;
    e = model(s, hi, lo, d, fin);
    @(negedge clk);
    sgn_mode = s; dvd_hi = hi; dvd_lo = lo; dvsr = d; flags_in = fin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
    chk({req, " rem"}, rem_out, e[63:32]);
    chk({req, " quo"}, quo_out, e[31:0]);
    chk({req, " flags"}, {27'd0, flags_out}, {27'd0, e[68:64]});
    chk({req, " dz"}, {31'd0, div_zero}, {31'd0, e[69]});
  endtask

  task automatic t_reset();
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset dz", {31'd0, div_zero}, 32'd0);
    chk("R1 reset rem", rem_out, 32'd0);
    chk("R1 reset quo", quo_out, 32'd0);
    chk("R1 reset flags", {27'd0, flags_out}, 32'd0);
  endtask

  task automatic t_handshake();
    logic [69:0] e;
    int dones;
    e = model(1'b0, 32'h0000_0003, 32'h0000_0007, 32'h0001_0005, 5'h00);
    @(negedge clk);
    sgn_mode = 1'b0; dvd_hi = 32'h3; dvd_lo = 32'h7; dvsr = 32'h0001_0005; flags_in = 5'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", {31'd0, busy}, 32'd1);
    // start while busy with other operands must be ignored
    dvd_hi = 32'h0; dvd_lo = 32'h99; dvsr = 32'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R1");
    chk("R1 done with busy low", {31'd0, busy}, 32'd0);
    chk("R1 ignored start rem", rem_out, e[63:32]);
    chk("R1 ignored start quo", quo_out, e[31:0]);
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R1 single done pulse", dones, 32'd0);
  endtask

  task automatic t_divzero();
    run("R2 dz unsigned", 1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'd0, 5'h1B);
    run("R2 dz signed", 1'b1, 32'h8000_0000, 32'h1, 32'd0, 5'h04);
  endtask

  task automatic t_unsigned();
    run("R3 basic", 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0003, 5'h00);
    run("R3 exact", 1'b0, 32'h0000_0000, 32'd100, 32'd10, 5'h00);
    run("R3 big quotient", 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h10);
  endtask

  task automatic t_overflow();
    run("R4 hi equals d", 1'b0, 32'h0000_0005, 32'h0, 32'h5, 5'h1F);
    run("R4 hi above d", 1'b0, 32'hFFFF_0000, 32'h1234, 32'h1000, 5'h0D);
    run("R4 signed mag", 1'b1, 32'hFFFF_FFF0, 32'h0, 32'h0000_0010, 5'h05);
  endtask

  task automatic t_signed();
    run("R5 neg dividend", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 5'h00);
    run("R5 neg divisor", 1'b1, 32'h0, 32'd7, 32'hFFFF_FFFE, 5'h00);
    run("R5 both neg", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 5'h10);
    run("R5 wide neg", 1'b1, 32'hFFFF_FFF0, 32'h1234_5678, 32'h0012_3457, 5'h00);
  endtask

  task automatic t_signed_range();
    run("R6 neg min ok", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 5'h00);
    run("R6 neg too big", 1'b1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 5'h00);
    run("R6 pos too big", 1'b1, 32'h0, 32'h8000_0000, 32'd1, 5'h08);
    run("R6 pos max ok", 1'b1, 32'h0, 32'h7FFF_FFFF, 32'd1, 5'h00);
  endtask

  task automatic t_zero_dividend();
    run("R7 zero unsigned", 1'b0, 32'h0, 32'h0, 32'h1234, 5'h13);
    run("R7 zero signed", 1'b1, 32'h0, 32'h0, 32'hFFFF_FFFF, 5'h00);
  endtask

  task automatic t_small_dividend();
    run("R8 lo below d", 1'b0, 32'h0, 32'h0000_0009, 32'h0000_000A, 5'h10);
    run("R8 signed neg", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'h0000_0100, 5'h00);
  endtask

  task automatic t_flags();
    run("R9 X kept set", 1'b0, 32'h0, 32'd50, 32'd7, 5'h1F);
    run("R9 X kept clear", 1'b0, 32'h0, 32'd50, 32'd7, 5'h0F);
    run("R9 N from quotient", 1'b0, 32'h0000_0001, 32'h0, 32'h0000_0002, 5'h00);
  endtask

  task automatic t_short_path();
    for (int i = 0; i < 60; i++) begin
      logic [31:0] d, hi;
      d  = (rnd() & 32'h0000_FFFF) | 32'd2;
      hi = rnd() % d;
      run("R10 short divisor", i[0], hi, rnd(), d, 5'(rnd()));
    end
  endtask

  task automatic t_long_path();
    for (int k = 16; k < 32; k++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] d, hi;
        d  = (32'd1 << k) | (rnd() & ((32'd1 << k) - 32'd1));
        hi = rnd() & ((32'd1 << k) - 32'd1);
        run("R11 long divisor", 1'b0, hi, rnd(), d, 5'(rnd()));
      end
    end
    for (int i = 0; i < 150; i++)
      run("R11 random", i[0], rnd(), rnd(), rnd(), 5'(rnd()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_divzero();
    t_unsigned();
    t_overflow();
    t_signed();
    t_signed_range();
    t_zero_dividend();
    t_small_dividend();
    t_flags();
    t_short_path();
    t_long_path();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule